// File: doc/BRIEF.md
# Mask-Addressed Register Transfer Unit

This unit carries out register-to-register operations over three 16-bit working registers: an accumulator (A), a multiplier-quotient register (Q) and an auxiliary register (M). Each operation has a source mask, a destination mask and an operation select. Every register named in the source mask feeds a bitwise OR to form one operand. A small operation is applied to that operand, and the result goes to every register named in the destination mask on one clock edge. One operation can therefore load several registers at once.

An all-zero mask means a fourth register that is not held on chip. It is a second index register stored in the highest word of memory. It is reached through a simple request/acknowledge memory port. A zero source mask causes a memory read. A zero destination mask causes a memory write. When both masks are zero, the read comes before the write. Operations that stay on chip complete in the cycle they are accepted. Operations that touch memory hold `ready` low until their last acknowledge.

Top module: `rt_xfer_unit`

## Requirements
- R1: After reset, regA, regQ and regM are 0, ready is 1, done is 0 and memReq is 0.
- R2: The destination mask uses bit 0 for M, bit 1 for Q and bit 2 for A. Every selected register receives the same result on one clock edge.
- R3: A register whose bit is clear in a nonzero destination mask keeps its value.
- R4: The source mask uses the same bit assignment as the destination mask. With several bits set, the operand is the bitwise OR of the selected registers.
- R5: opSel selects the operation: 0 passes the operand, 1 gives its ones' complement, 2 adds one and 3 subtracts one. Both arithmetic cases wrap modulo 2^16.
- R6: A zero source mask issues a read (memWe=0) at the top address, all ones (0x7FFF by default). The returned memRdata is the operand.
- R7: A zero destination mask issues a write (memWe=1) of the result to the top address. No on-chip register changes.
- R8: When neither mask is zero, the registers update on the accepting edge. done is 1 for the cycle after that edge, and ready stays 1.
- R9: memReq stays high until memAck. When both masks are zero, the read completes before the write starts. done pulses for one cycle after the final acknowledge. While ready is 0, opValid is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation offered; taken when ready is 1 |
| srcSel | input | 3 | Source mask (bit0 M, bit1 Q, bit2 A; 0 = memory index register) |
| dstSel | input | 3 | Destination mask (same encoding) |
| opSel | input | 2 | 0 pass, 1 complement, 2 increment, 3 decrement |
| ready | output | 1 | Unit idle and able to take an operation |
| done | output | 1 | One-cycle completion pulse |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 15 | Word address (always the top word) |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with memAck |
| memAck | input | 1 | Access completes on this cycle |
| regA | output | 16 | Accumulator contents |
| regQ | output | 16 | Multiplier-quotient register contents |
| regM | output | 16 | Auxiliary register contents |

## Verification
The bench builds the unit with its default parameters: a 16-bit word and a 15-bit address, so the memory-held register sits at 0x7FFF. Its memory model answers every access after a two-cycle wait. This makes the held-request and read-then-write ordering visible, and leaves room to offer a competing operation while the unit is busy. Operands such as 0x1234 OR 0xEDCB reach 0xFFFF, so increment and decrement wrap at the word boundary.

// File: rtl/rt_xfer_pkg.sv
package rt_xfer_pkg;
  localparam int REG_CNT = 3;
  localparam int IDX_M = 0;
  localparam int IDX_Q = 1;
  localparam int IDX_A = 2;

  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_NOT  = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } state_e;

  typedef struct packed {
    logic latchOp;
    logic useLatched;
    logic srcFromMem;
    logic regWrite;
    logic resultLoad;
  } ctrl_t;
endpackage

// File: rtl/rt_xfer_ctrl.sv
module rt_xfer_ctrl
  import rt_xfer_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  opValid,
  input  logic  srcZero,
  input  logic  dstZero,
  input  logic  dstZeroHeld,
  input  logic  memAck,
  output logic  ready,
  output logic  done,
  output logic  memReq,
  output logic  memWe,
  output ctrl_t ctrl
);
  state_e state, stateNext;
  logic doneNext;

  always_comb begin
    stateNext = state;
    doneNext = 1'b0;
    ctrl = '0;
    ready = 1'b0;
    memReq = 1'b0;
    memWe = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ready = 1'b1;
        if (opValid) begin
          ctrl.latchOp = 1'b1;
          if (srcZero) begin
            stateNext = ST_READ;
          end else if (dstZero) begin
            ctrl.resultLoad = 1'b1;
            stateNext = ST_WRITE;
          end else begin
            ctrl.regWrite = 1'b1;
            doneNext = 1'b1;
          end
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        ctrl.useLatched = 1'b1;
        ctrl.srcFromMem = 1'b1;
        if (memAck) begin
          if (dstZeroHeld) begin
            ctrl.resultLoad = 1'b1;
            stateNext = ST_WRITE;
          end else begin
            ctrl.regWrite = 1'b1;
            doneNext = 1'b1;
            stateNext = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe = 1'b1;
        ctrl.useLatched = 1'b1;
        if (memAck) begin
          doneNext = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done <= 1'b0;
    end else begin
      state <= stateNext;
      done <= doneNext;
    end
  end

  // R9: an unanswered request stays up with the same direction
  p_req_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));

  // R9: a read acknowledge with a memory destination is followed by a write
  p_read_then_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck && dstZeroHeld) |=> (memReq && memWe));

  // R8: on-chip operation completes without leaving idle
  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ready && opValid && !srcZero && !dstZero) |=> (done && ready));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/rt_xfer_datapath.sv
module rt_xfer_datapath
  import rt_xfer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [REG_CNT-1:0] srcSel,
  input  logic [REG_CNT-1:0] dstSel,
  input  logic [1:0]        opSel,
  input  logic [DATA_W-1:0] memRdata,
  output logic              dstZeroHeld,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] regOut [REG_CNT]
);
  logic [REG_CNT-1:0] dstHeld;
  logic [1:0]         opHeld;
  logic [REG_CNT-1:0] dstCur;
  logic [1:0]         opCur;
  logic [DATA_W-1:0]  orSrc;
  logic [DATA_W-1:0]  operand;
  logic [DATA_W-1:0]  result;
  logic [DATA_W-1:0]  resultHeld;

  function automatic logic [DATA_W-1:0] applyOp(input logic [1:0] op,
                                               input logic [DATA_W-1:0] v);
    unique case (op_e'(op))
      OP_PASS: return v;
      OP_NOT:  return ~v;
      OP_INC:  return v + DATA_W'(1);
      OP_DEC:  return v - DATA_W'(1);
      default: return v;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstHeld <= '0;
      opHeld <= '0;
    end else if (ctrl.latchOp) begin
      dstHeld <= dstSel;
      opHeld <= opSel;
    end
  end

  assign dstCur = ctrl.useLatched ? dstHeld : dstSel;
  assign opCur = ctrl.useLatched ? opHeld : opSel;
  assign dstZeroHeld = (dstHeld == '0);

  always_comb begin
    orSrc = '0;
    for (int i = 0; i < REG_CNT; i++) begin
      if (srcSel[i]) orSrc = orSrc | regOut[i];
    end
  end

  assign operand = ctrl.srcFromMem ? memRdata : orSrc;
  assign result = applyOp(opCur, operand);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultHeld <= '0;
    else if (ctrl.resultLoad) resultHeld <= result;
  end
  assign memWdata = resultHeld;

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regOut[g] <= '0;
      else if (ctrl.regWrite && dstCur[g]) regOut[g] <= result;
    end

    // R3: a register left out of the mask holds its value
    p_unselected_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.regWrite && !dstCur[g]) |=> $stable(regOut[g]));
  end

  // R2: broadcast writes land identically in M and Q, and in Q and A
  p_broadcast_mq_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.regWrite && dstCur[IDX_M] && dstCur[IDX_Q]) |=> (regOut[IDX_M] == regOut[IDX_Q]));
  p_broadcast_qa_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.regWrite && dstCur[IDX_Q] && dstCur[IDX_A]) |=> (regOut[IDX_Q] == regOut[IDX_A]));

  // R7: a memory-held destination never changes on-chip registers
  p_no_reg_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.regWrite && ctrl.useLatched) |-> !dstZeroHeld);
endmodule

// File: rtl/rt_xfer_unit.sv
module rt_xfer_unit
  import rt_xfer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        srcSel,
  input  logic [2:0]        dstSel,
  input  logic [1:0]        opSel,
  output logic              ready,
  output logic              done,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regQ,
  output logic [DATA_W-1:0] regM
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  ctrl_t ctrl;
  logic dstZeroHeld;
  logic [DATA_W-1:0] regOut [REG_CNT];

  rt_xfer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid),
    .srcZero(srcSel == '0), .dstZero(dstSel == '0),
    .dstZeroHeld(dstZeroHeld), .memAck(memAck),
    .ready(ready), .done(done), .memReq(memReq), .memWe(memWe),
    .ctrl(ctrl)
  );

  rt_xfer_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .srcSel(srcSel), .dstSel(dstSel), .opSel(opSel),
    .memRdata(memRdata), .dstZeroHeld(dstZeroHeld),
    .memWdata(memWdata), .regOut(regOut)
  );

  assign memAddr = TOP_ADDR;
  assign regA = regOut[IDX_A];
  assign regQ = regOut[IDX_Q];
  assign regM = regOut[IDX_M];

  // R9: no new operation is taken while busy; registers hold during a pure read wait
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(regA) && $stable(regQ) && $stable(regM)));

  // R7: a memory-destination acceptance leaves the idle state
  p_mem_dst_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ready && opValid && dstSel == '0) |=> !ready);
endmodule

// File: tb/rt_xfer_unit_tb.sv
module rt_xfer_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;
  localparam int NVEC = 11;

  logic clk = 0, rstN = 0, opValid = 0;
  logic [2:0] srcSel = 0, dstSel = 0;
  logic [1:0] opSel = 0;
  logic ready, done, memReq, memWe, memAck;
  logic [14:0] memAddr;
  logic [15:0] memWdata, memRdata, regA, regQ, regM;
  logic [15:0] x2Mem;
  int checks = 0, errors = 0, cycles = 0;
  int rdCount, wrCount, waitCnt;
  logic orderBad, addrBad;

  // vector: {src, dst, op}
  localparam logic [7:0] VEC [NVEC] = '{
    {3'b000, 3'b100, 2'd0}, {3'b100, 3'b001, 2'd1}, {3'b101, 3'b010, 2'd2},
    {3'b010, 3'b111, 2'd3}, {3'b100, 3'b000, 2'd2}, {3'b000, 3'b011, 2'd0},
    {3'b000, 3'b000, 2'd1}, {3'b000, 3'b110, 2'd3}, {3'b001, 3'b100, 2'd1},
    {3'b011, 3'b001, 2'd2}, {3'b111, 3'b000, 2'd0}};

  rt_xfer_unit u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .srcSel(srcSel), .dstSel(dstSel),
    .opSel(opSel), .ready(ready), .done(done), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .regA(regA), .regQ(regQ), .regM(regM));

  always #(CLK_PERIOD/2) clk = ~clk;
  assign memRdata = x2Mem;

  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 0; waitCnt <= 0;
    end else begin
      memAck <= 0;
      if (memReq && !memAck) begin
        if (waitCnt == LAT) begin
          memAck <= 1; waitCnt <= 0;
          if (memAddr != 15'h7FFF) addrBad <= 1;
          if (memWe) begin x2Mem <= memWdata; wrCount <= wrCount + 1; end
          else begin
            rdCount <= rdCount + 1;
            if (wrCount != 0) orderBad <= 1;
          end
        end else waitCnt <= waitCnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] opModel(input logic [1:0] op, input logic [15:0] v);
    case (op)
      2'd0: return v;
      2'd1: return ~v;
      2'd2: return v + 16'd1;
      default: return v - 16'd1;
    endcase
  endfunction

  task automatic clearLog();
    rdCount = 0; wrCount = 0; orderBad = 0; addrBad = 0;
  endtask

  task automatic doOp(input logic [2:0] s, input logic [2:0] d, input logic [1:0] o);
    @(negedge clk);
    srcSel = s; dstSel = d; opSel = o; opValid = 1;
    @(negedge clk);
    opValid = 0;
    for (int k = 0; k < 50 && !done; k++) @(negedge clk);
  endtask

  logic [15:0] mA, mQ, mM, mX, opnd, res;

  initial begin
    x2Mem = 16'h1234;
    clearLog();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 regA", regA, 0); check("R1 regQ", regQ, 0); check("R1 regM", regM, 0);
    check("R1 ready/done/memReq", {13'd0, ready, done, memReq}, 16'b100);
    rstN = 1;
    mA = 0; mQ = 0; mM = 0; mX = 16'h1234;

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] s, d; logic [1:0] o;
      {s, d, o} = VEC[i];
      clearLog();
      doOp(s, d, o);
      opnd = (s == 0) ? mX : ((s[2] ? mA : 0) | (s[1] ? mQ : 0) | (s[0] ? mM : 0));
      res = opModel(o, opnd);
      if (d == 0) mX = res;
      else begin
        if (d[2]) mA = res;
        if (d[1]) mQ = res;
        if (d[0]) mM = res;
      end
      check($sformatf("R2/R3/R4/R5 vec%0d regA", i), regA, mA);
      check($sformatf("R2/R3/R4/R5 vec%0d regQ", i), regQ, mQ);
      check($sformatf("R2/R3/R4/R5 vec%0d regM", i), regM, mM);
      check($sformatf("R7 vec%0d top word", i), x2Mem, mX);
      check($sformatf("R6 vec%0d reads", i), 16'(rdCount), (s == 0) ? 16'd1 : 16'd0);
      check($sformatf("R7 vec%0d writes", i), 16'(wrCount), (d == 0) ? 16'd1 : 16'd0);
      check($sformatf("R9 vec%0d order/addr R6", i), {14'd0, orderBad, addrBad}, 0);
    end

    // R8: on-chip op timing: update and done at the first negedge after accept
    @(negedge clk);
    srcSel = 3'b100; dstSel = 3'b010; opSel = 2'd1; opValid = 1;
    @(negedge clk);
    opValid = 0;
    check("R8 done after accept", {15'd0, done}, 1);
    check("R8 ready stays high", {15'd0, ready}, 1);
    check("R8 regQ updated", regQ, ~mA);
    mQ = ~mA;
    @(negedge clk);
    check("R9 done single pulse", {15'd0, done}, 0);

    // R9: memory op with competing opValid while busy
    x2Mem = 16'h0F0F; mX = 16'h0F0F;
    @(negedge clk);
    srcSel = 3'b000; dstSel = 3'b000; opSel = 2'd2; opValid = 1;
    @(negedge clk);
    srcSel = 3'b111; dstSel = 3'b111; opSel = 2'd2;
    check("R9 ready low while busy", {15'd0, ready}, 0);
    check("R9 request up", {15'd0, memReq}, 1);
    check("R6 first access is read", {15'd0, memWe}, 0);
    for (int k = 0; k < 50 && !done; k++) @(negedge clk);
    opValid = 0;
    check("R9 top word incremented", x2Mem, 16'h0F10);
    check("R9 regA ignored", regA, mA);
    check("R9 regQ ignored", regQ, mQ);
    check("R9 regM ignored", regM, mM);
    @(negedge clk);
    check("R9 ready after done", {15'd0, ready}, 1);
    check("R9 no late accept regA", regA, mA);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule